// File: doc/BRIEF.md
# Instruction Fetch Next-PC Unit

This block is the front of a single-cycle processor. It holds a 32-bit program counter and presents, in the same cycle, the 32-bit instruction word stored in a small internal instruction memory at that counter. On every rising clock edge the counter advances, together with all other state in the processor. The new value is either the following word address or a PC-relative branch target taken from the low 16 bits of the current instruction.

The surrounding control logic drives a branch-select line, and the register-compare stage drives an equality flag. A branch is taken only when both are high. The target is the sequential address plus the sign-extended immediate scaled by four, so backward branches work and no general ALU is needed for address arithmetic. The instruction memory is filled through a plain write port, usually while reset is held. The port has no back-pressure: a write is accepted on every edge where the enable is high.

Top module: `fetch_npc_unit`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 on the clock edge where `rst` is high.
- R2: `instr_o` equals, without a clock delay, the memory word whose index is `pc_o[9:2]`. With the default 256-word depth, the index is 8 bits wide.
- R3: The two low bits of `pc_o` are always 0.
- R4: When `br_sel` is 0, the next value of `pc_o` is the current value plus 4.
- R5: When `br_sel` is 1 and `eq_flag` is 0, the next value of `pc_o` is the current value plus 4.
- R6: When `br_sel` and `eq_flag` are both 1, the next value of `pc_o` is the current value plus 4 plus the signed value of `instr_o[15:0]` multiplied by 4.
- R7: A negative immediate moves the counter backward. An immediate of 0xFFFF on a taken branch leaves `pc_o` unchanged.
- R8: When `load_en` is high at a rising edge, the word at index `load_idx` is replaced by `load_data`. After that edge, the new word appears on `instr_o` whenever `pc_o[9:2]` equals that index.
- R9: `eq_flag` has no effect on the next counter value while `br_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the counter |
| br_sel | input | 1 | Branch selected by control logic |
| eq_flag | input | 1 | Register operands compared equal |
| load_en | input | 1 | Write strobe of the memory load port |
| load_idx | input | 8 | Word index written by the load port |
| load_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word at the current counter |

## Verification
The assertions assume that every memory word the counter reaches has been written before reset is released. If that does not hold, the immediate that feeds the branch target is undefined. The stimulus fills all 256 words while `rst` is high, and it rewrites words only while reset is held or at an index it then models itself. The assertions also assume that `br_sel` and `eq_flag` are known at every edge after reset. The bench drives them at the falling edge to 0 or 1.

// File: rtl/fnu_pkg.sv
package fnu_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned IMM_W = 16;
  localparam int unsigned ALIGN = 2;

  typedef logic [XLEN-1:0]  word_t;
  typedef logic [IMM_W-1:0] imm_t;

  // Signed immediate scaled to a byte offset in words.
  function automatic word_t scaled_offset(input imm_t imm);
    word_t ext;
    ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    return ext << ALIGN;
  endfunction
endpackage

// File: rtl/fnu_imem.sv
module fnu_imem #(
  parameter int unsigned WORDS = 256,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                we,
  input  logic [IDX_W-1:0]    waddr,
  input  fnu_pkg::word_t      wdata,
  input  logic [IDX_W-1:0]    raddr,
  output fnu_pkg::word_t      rdata
);
  fnu_pkg::word_t mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read side is purely combinational.
  assign rdata = mem[raddr];
endmodule

// File: rtl/fnu_next_pc.sv
module fnu_next_pc (
  input  fnu_pkg::word_t pc,
  input  fnu_pkg::imm_t  imm,
  input  logic           br_sel,
  input  logic           eq_flag,
  output fnu_pkg::word_t npc
);
  import fnu_pkg::*;

  localparam word_t STEP = word_t'(1) << ALIGN;

  word_t seq_pc;
  word_t tgt_pc;
  logic  take;

  always_comb begin
    seq_pc = pc + STEP;
    tgt_pc = seq_pc + scaled_offset(imm);
    take   = br_sel & eq_flag;
    npc    = take ? tgt_pc : seq_pc;
  end
endmodule

// File: rtl/fnu_pc_reg.sv
module fnu_pc_reg (
  input  logic           clk,
  input  logic           rst,
  input  fnu_pkg::word_t d,
  output fnu_pkg::word_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/fetch_npc_unit.sv
module fetch_npc_unit #(
  parameter int unsigned MEM_WORDS = 256,
  localparam int unsigned IDX_W = $clog2(MEM_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_sel,
  input  logic             eq_flag,
  input  logic             load_en,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [31:0]      load_data,
  output logic [31:0]      pc_o,
  output logic [31:0]      instr_o
);
  import fnu_pkg::*;

  word_t pc_q;
  word_t pc_d;
  word_t fetched;

  fnu_pc_reg u_pc (
    .clk (clk),
    .rst (rst),
    .d   (pc_d),
    .q   (pc_q)
  );

  fnu_imem #(.WORDS(MEM_WORDS)) u_imem (
    .clk   (clk),
    .we    (load_en),
    .waddr (load_idx),
    .wdata (load_data),
    .raddr (pc_q[IDX_W+ALIGN-1:ALIGN]),
    .rdata (fetched)
  );

  fnu_next_pc u_npc (
    .pc      (pc_q),
    .imm     (fetched[IMM_W-1:0]),
    .br_sel  (br_sel),
    .eq_flag (eq_flag),
    .npc     (pc_d)
  );

  assign pc_o    = pc_q;
  assign instr_o = fetched;
endmodule

// File: rtl/fetch_npc_unit_chk.sv
module fetch_npc_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        br_sel,
  input logic        eq_flag,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o
);
  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (pc_o == 32'd0)); // R1

  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00); // R3

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    !br_sel |=> (pc_o == $past(pc_o) + 32'd4)); // R4

  AST_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (br_sel && !eq_flag) |=> (pc_o == $past(pc_o) + 32'd4)); // R5

  AST_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (br_sel && eq_flag) |=>
      (pc_o == $past(pc_o) + 32'd4 + {{14{$past(instr_o[15])}}, $past(instr_o[15:0]), 2'b00})); // R6

  AST_SELF_LOOP: assert property (@(posedge clk) disable iff (rst)
    (br_sel && eq_flag && instr_o[15:0] == 16'hFFFF) |=> $stable(pc_o)); // R7
endmodule

bind fetch_npc_unit fetch_npc_unit_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .br_sel  (br_sel),
  .eq_flag (eq_flag),
  .pc_o    (pc_o),
  .instr_o (instr_o)
);

// File: tb/fetch_npc_unit_tb.sv
module fetch_npc_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_sel = 1'b0;
  logic        eq_flag = 1'b0;
  logic        load_en = 1'b0;
  logic [7:0]  load_idx = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc_o;
  logic [31:0] instr_o;

  logic [31:0] model_mem [256];
  logic [31:0] exp_pc;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fetch_npc_unit u_dut (
    .clk(clk), .rst(rst), .br_sel(br_sel), .eq_flag(eq_flag),
    .load_en(load_en), .load_idx(load_idx), .load_data(load_data),
    .pc_o(pc_o), .instr_o(instr_o)
  );

  function automatic logic [31:0] init_word(input int i);
    logic [15:0] imm;
    imm = 16'((i % 11) - 3);
    return {16'(i * 16'h9E37 + 16'h5A5A), imm};
  endfunction

  function automatic logic [31:0] offs(input logic [31:0] w);
    return {{14{w[15]}}, w[15:0], 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic step(input logic b, input logic e, input string req);
    logic [31:0] cur;
    cur = model_mem[exp_pc[9:2]];
    br_sel  = b;
    eq_flag = e;
    @(posedge clk);
    @(negedge clk);
    exp_pc = exp_pc + 32'd4 + ((b && e) ? offs(cur) : 32'd0);
    check(req, pc_o, exp_pc);
    check("R2", instr_o, model_mem[exp_pc[9:2]]);
    check("R3", {30'd0, pc_o[1:0]}, 32'd0);
  endtask

  task automatic load(input int idx, input logic [31:0] w);
    load_en = 1'b1; load_idx = 8'(idx); load_data = w;
    @(posedge clk);
    @(negedge clk);
    load_en = 1'b0;
    model_mem[idx] = w;
  endtask

  task automatic do_reset();
    rst = 1'b1; br_sel = 1'b0; eq_flag = 1'b0;
    @(posedge clk);
    @(negedge clk);
    exp_pc = 32'd0;
    check("R1", pc_o, 32'd0);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 256; i++) load(i, init_word(i));
    do_reset();
    check("R2", instr_o, model_mem[0]);
    rst = 1'b0;

    // Sequential flow with eq_flag toggling: R4, R9
    for (int k = 0; k < 40; k++) step(1'b0, k[0], "R4/R9");

    // Selected but unequal: R5
    for (int k = 0; k < 20; k++) step(1'b1, 1'b0, "R5");

    // Mixed sweep of all select/flag pairs: R6
    for (int k = 0; k < 1500; k++) begin
      logic [1:0] r;
      r = 2'($urandom_range(0, 3));
      step(r[1], r[0], "R6");
    end

    // Self-loop on immediate 0xFFFF: R7
    do_reset();
    load(0, 32'hC0DE_FFFF);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, "R9");
    check("R7", pc_o, 32'd4);

    // Largest forward offset 0x7FFF from 0: R6
    rst = 1'b1;
    load(0, 32'h0000_7FFF);
    do_reset();
    rst = 1'b0;
    step(1'b1, 1'b1, "R6");
    check("R6", pc_o, 32'h0002_0000);

    // Backward branch from word 10 by -6 words lands on word 5: R7
    rst = 1'b1;
    load(0, init_word(0));
    load(10, 32'h1111_FFFA);
    do_reset();
    rst = 1'b0;
    for (int k = 0; k < 10; k++) step(1'b0, 1'b0, "R4");
    step(1'b1, 1'b1, "R7");
    check("R7", pc_o, 32'd20);

    // Rewrite a word, then reach it sequentially: R8
    rst = 1'b1;
    load(3, 32'hFEED_0001);
    do_reset();
    rst = 1'b0;
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R4");
    check("R8", instr_o, 32'hFEED_0001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule